// File: doc/BRIEF.md
# Per-Bit Edge Detection Unit

This block watches a wide bus of discrete signals and reports, for each bit on its own, whether the edge type chosen for that bit has just occurred. Each bit has a 2-bit edge-type code and a 1-bit mask. A change is found by comparing the present input with a registered copy of the value from the previous cycle. The results are a per-bit event vector and a single flag that is high when any event is present. A trace collector can use the flag to decide whether to capture a sample.

Configuration is indexed. The caller first writes the number of the bit to configure, and then writes one value. That value goes either to the bit's edge-type code or to its mask, depending on a select input. Both tables can be read back without side effects as packed 32-bit words. `NBITS` must be a power of two and at least 64. Its default is 256.

Top module: `edge_det`

## Requirements
- R1: A bit with edge code 2'b00 raises its event when its input goes from 0 in the previous cycle to 1 in the present cycle, and at no other time.
- R2: A bit with edge code 2'b01 raises its event only when its input goes from 1 to 0.
- R3: A bit with edge code 2'b10 raises its event on any change of its input, rising or falling.
- R4: A bit with edge code 2'b11 never raises an event.
- R5: A bit whose mask is 1 never raises an event. A bit whose mask is 0 reports according to its code.
- R6: `evt_any` is high exactly when at least one bit of `evt` is high.
- R7: Reset clears every code to 2'b00 and every mask to 0. In the first cycle after reset is released, `evt` is all zero, whatever the input.
- R8: A pulse on `idx_wr` stores `idx_data` as a pending index. A later pulse on `val_wr` applies to that bit. With `val_sel`=0 it writes `val_data[1:0]` to the bit's code. With `val_sel`=1 it writes `val_data[0]` to the bit's mask.
- R9: A `val_wr` pulse consumes the pending index. A `val_wr` pulse that arrives with no index write since the last value write changes nothing.
- R10: With `rd_sel`=0, bits [2k+1:2k] of `rd_data` hold the code of bit 16·`rd_word`+k. With `rd_sel`=1, bit k holds the mask of bit 32·`rd_word`+k. Mask word numbers of NBITS/32 and above read as zero.
- R11: All bits are evaluated at once and independently. Any mix of codes, masks and input patterns gives, in every cycle, the per-bit result of R1 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | NBITS | Monitored signal bus |
| idx_wr | input | 1 | Index write strobe |
| idx_data | input | log2(NBITS) | Bit number to configure |
| val_wr | input | 1 | Value write strobe |
| val_sel | input | 1 | 0: write the edge code, 1: write the mask |
| val_data | input | 2 | Value to write (the mask uses bit 0) |
| rd_sel | input | 1 | 0: read code words, 1: read mask words |
| rd_word | input | log2(NBITS/16) | Word number to read |
| rd_data | output | 32 | Packed readback word |
| evt | output | NBITS | Per-bit event vector |
| evt_any | output | 1 | OR of all event bits |

## Verification
The assertions check, on every cycle and for every bit, four things:
- An event appears only on a bit whose input changed.
- A masked bit or a bit with code 11 stays quiet.
- The direction of an event agrees with its code.
- Nothing fires in the first cycle after reset, and a value write with no pending index leaves both tables unchanged.

Only the bench's scenarios can show the following:
- The indexed write lands on the intended bit and field.
- Readback packs codes and masks at the stated positions.
- A full mix of codes, masks and pseudo-random input patterns matches an independent per-bit model.

// File: rtl/edge_det.sv
module edge_det #(
  parameter int NBITS = 256,
  localparam int IW = $clog2(NBITS),
  localparam int RW = $clog2(NBITS / 16)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] sig_in,
  input  logic             idx_wr,
  input  logic [IW-1:0]    idx_data,
  input  logic             val_wr,
  input  logic             val_sel,
  input  logic [1:0]       val_data,
  input  logic             rd_sel,
  input  logic [RW-1:0]    rd_word,
  output logic [31:0]      rd_data,
  output logic [NBITS-1:0] evt,
  output logic             evt_any
);

  logic [NBITS-1:0]   prev_q, mask_q;
  logic [2*NBITS-1:0] ctrl_q;
  logic               prev_valid, armed;
  logic [IW-1:0]      idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_valid <= 1'b0;
      mask_q     <= '0;
      ctrl_q     <= '0;
      armed      <= 1'b0;
      idx_q      <= '0;
    end else begin
      prev_q     <= sig_in;
      prev_valid <= 1'b1;
      if (val_wr && armed) begin
        if (val_sel) mask_q[idx_q] <= val_data[0];
        else         ctrl_q[{idx_q, 1'b0} +: 2] <= val_data;
      end
      if (idx_wr) begin
        idx_q <= idx_data;
        armed <= 1'b1;
      end else if (val_wr) begin
        armed <= 1'b0;
      end
    end
  end

  logic [31:0] cword, mword;
  assign cword   = ctrl_q[{rd_word, 5'b0} +: 32];
  assign mword   = rd_word[RW-1] ? 32'b0 : mask_q[{rd_word[RW-2:0], 5'b0} +: 32];
  assign rd_data = rd_sel ? mword : cword;

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    logic [1:0] code;
    logic       rise, fall, hit;
    assign code = ctrl_q[2*g +: 2];
    assign rise = sig_in[g] & ~prev_q[g];
    assign fall = ~sig_in[g] & prev_q[g];
    assign hit  = (code == 2'b00) ? rise :
                  (code == 2'b01) ? fall :
                  (code == 2'b10) ? (rise | fall) : 1'b0;
    assign evt[g] = hit & ~mask_q[g] & prev_valid;

    a_r1_rise_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b00 && evt[g]) |-> (sig_in[g] && !prev_q[g]));
    a_r2_fall_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b01 && evt[g]) |-> (!sig_in[g] && prev_q[g]));
    a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b11) |-> !evt[g]);
  end

  assign evt_any = |evt;

  a_r3_change_only: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~(sig_in ^ prev_q)) == '0);
  a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & mask_q) == '0);
  a_r6_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any == (evt != '0));
  a_r7_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> evt == '0);
  a_r9_orphan_value: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && !armed) |=> ($stable(ctrl_q) && $stable(mask_q)));

endmodule

// File: tb/sim_edge_det.sv
module sim_edge_det;
  localparam int N = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] sig_in = '0;
  logic         idx_wr = 1'b0, val_wr = 1'b0, val_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0]   idx_data = '0;
  logic [1:0]   val_data = '0;
  logic [3:0]   rd_word = '0;
  logic [31:0]  rd_data;
  logic [N-1:0] evt;
  logic         evt_any;

  edge_det #(.NBITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .idx_wr(idx_wr), .idx_data(idx_data),
    .val_wr(val_wr), .val_sel(val_sel), .val_data(val_data), .rd_sel(rd_sel),
    .rd_word(rd_word), .rd_data(rd_data), .evt(evt), .evt_any(evt_any));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [1:0]   m_ctrl [N];
  logic         m_mask [N];
  logic         m_armed = 1'b0;
  logic [7:0]   m_idx = '0;
  logic [N-1:0] m_prev = '0;
  logic [31:0]  seed = 32'h1234_5678;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_evt(logic [N-1:0] cur, logic [N-1:0] prv);
    logic [N-1:0] e = '0;
    for (int i = 0; i < N; i++) begin
      logic r = cur[i] & ~prv[i];
      logic f = ~cur[i] & prv[i];
      logic h = (m_ctrl[i] == 2'b00) ? r : (m_ctrl[i] == 2'b01) ? f :
                (m_ctrl[i] == 2'b10) ? (r | f) : 1'b0;
      e[i] = h & ~m_mask[i];
    end
    return e;
  endfunction

  task automatic step(string req, logic [N-1:0] v);
    logic [N-1:0] e;
    @(negedge clk);
    sig_in = v;
    #1;
    e = model_evt(v, m_prev);
    chk(req, evt, e);
    chk("R6", {{(N-1){1'b0}}, evt_any}, {{(N-1){1'b0}}, (e != '0)});
    @(posedge clk);
    m_prev = v;
  endtask

  task automatic wr_idx(int i);
    @(negedge clk);
    idx_wr = 1'b1; idx_data = 8'(i);
    @(negedge clk);
    idx_wr = 1'b0;
    m_armed = 1'b1; m_idx = 8'(i);
  endtask

  task automatic wr_val(bit sel, logic [1:0] v);
    @(negedge clk);
    val_wr = 1'b1; val_sel = sel; val_data = v;
    @(negedge clk);
    val_wr = 1'b0;
    if (m_armed) begin
      if (sel) m_mask[m_idx] = v[0];
      else     m_ctrl[m_idx] = v;
    end
    m_armed = 1'b0;
  endtask

  task automatic cfg(int i, logic [1:0] code, bit msk);
    wr_idx(i); wr_val(1'b0, code);
    wr_idx(i); wr_val(1'b1, {1'b0, msk});
  endtask

  task automatic rd_chk(string req, bit sel, int w);
    logic [31:0] e = '0;
    rd_sel = sel; rd_word = 4'(w);
    #1;
    for (int k = 0; k < 32; k++) begin
      if (sel) e[k] = (w < N/32) ? m_mask[32*w + k] : 1'b0;
    end
    for (int k = 0; k < 16; k++) begin
      if (!sel) e[2*k +: 2] = m_ctrl[16*w + k];
    end
    chk(req, {{(N-32){1'b0}}, rd_data}, {{(N-32){1'b0}}, e});
  endtask

  function automatic logic [N-1:0] rand_vec();
    logic [N-1:0] v;
    for (int k = 0; k < N/32; k++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      v[32*k +: 32] = seed;
    end
    return v;
  endfunction

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin m_ctrl[i] = 2'b00; m_mask[i] = 1'b0; end
    repeat (3) @(negedge clk);
    sig_in = '1; rst_n = 1'b1;
    #1;
    chk("R7 first cycle", evt, '0);
    rd_chk("R7 ctrl reset", 1'b0, 0);
    rd_chk("R7 mask reset", 1'b1, 0);
    @(posedge clk);
    m_prev = '1;
    step("R2 R1 all fall under rise code", '0);
  endtask

  task automatic t_rise();
    logic [N-1:0] v = '0;
    v[5] = 1'b1;
    step("R1 rise bit5", v);
    step("R1 fall bit5 no event", '0);
  endtask

  task automatic t_fall();
    logic [N-1:0] v = '0;
    cfg(9, 2'b01, 1'b0);
    rd_chk("R8 R10 ctrl word0", 1'b0, 0);
    v[9] = 1'b1;
    step("R2 rise on fall bit", v);
    step("R2 fall bit9", '0);
  endtask

  task automatic t_toggle();
    logic [N-1:0] v = '0;
    cfg(200, 2'b10, 1'b0);
    rd_chk("R3 R10 ctrl word12", 1'b0, 12);
    v[200] = 1'b1;
    step("R3 toggle up", v);
    step("R3 toggle down", '0);
  endtask

  task automatic t_reserved();
    logic [N-1:0] v = '0;
    cfg(255, 2'b11, 1'b0);
    v[255] = 1'b1;
    step("R4 reserved up", v);
    step("R4 reserved down", '0);
  endtask

  task automatic t_mask();
    logic [N-1:0] v = '0;
    cfg(5, 2'b00, 1'b1);
    wr_idx(255); wr_val(1'b1, 2'b01);
    rd_chk("R5 R10 mask word0", 1'b1, 0);
    rd_chk("R10 mask word7", 1'b1, 7);
    rd_chk("R10 mask word8 zero", 1'b1, 8);
    v[5] = 1'b1; v[6] = 1'b1;
    step("R5 masked bit5 unmasked bit6", v);
    step("R5 back low", '0);
  endtask

  task automatic t_orphan();
    wr_idx(40); wr_val(1'b0, 2'b01);
    wr_val(1'b0, 2'b10);
    wr_val(1'b1, 2'b01);
    rd_chk("R9 orphan ctrl ignored", 1'b0, 2);
    rd_chk("R9 orphan mask ignored", 1'b1, 1);
  endtask

  task automatic t_mix();
    for (int i = 0; i < N; i++) cfg(i, 2'(i % 4), (i % 7) == 3);
    for (int w = 0; w < 16; w++) rd_chk("R10 ctrl sweep", 1'b0, w);
    for (int w = 0; w < 16; w++) rd_chk("R10 mask sweep", 1'b1, w);
    for (int s = 0; s < 60; s++) step("R11 mixed pattern", rand_vec());
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_toggle();
    t_reserved();
    t_mask();
    t_orphan();
    t_mix();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule